// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block translates virtual addresses into physical addresses on 4 KB pages. It holds a set of page mappings, each tagged with an address space identifier. Every lookup compares against all slots at once, with no set indexing. A mapping can be marked global, which makes it match in every address space. When no valid slot matches, the block does not fetch anything. It reports a miss, and a software handler builds the mapping and installs it through the write port.

The low slots form a reserved region, fixed at 8 of 64 by default. Slots in this region are changed only by writes that name their index explicitly. The other slots can also be filled by a "write at victim" command. That command uses the value of a victim counter. The counter counts down by one every cycle through the non-reserved range and then wraps, so its value always lies outside the reserved region. Lookup results are registered and appear one cycle after the request.

Top module: `page_xlat_buffer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `lk_done`, `lk_hit` and `lk_miss` are 0 and `victim_idx` is 63. After reset every slot is invalid, so every lookup misses until a slot is written.
- R2: A lookup with `lk_req`=1 produces `lk_done`=1 on the next cycle. If a slot hits, that cycle also shows `lk_hit`=1, `lk_miss`=0, `lk_paddr` = {slot frame number, `lk_vaddr[11:0]`} and `lk_slot` = the index of that slot.
- R3: A lookup that matches no valid slot gives `lk_miss`=1, `lk_hit`=0, `lk_paddr`=0 and `lk_slot`=0 one cycle later. Nothing is installed as a result.
- R4: A slot whose global bit is 0 matches only when both the page number (`lk_vaddr[31:12]`) and `lk_asid` are equal to its stored values. Two slots may hold the same page number under different identifiers.
- R5: A slot whose global bit is 1 matches on the page number alone, whatever the value of `lk_asid`.
- R6: When `wr_en`=1 and `wr_victim`=0, the slot at `wr_slot` (any of 0 to 63) is written at the clock edge. Writing with `wr_valid`=0 removes the slot from matching.
- R7: After reset, `victim_idx` counts down by 1 every cycle from 63 to 8 and then returns to 63. It never shows a value below 8.
- R8: When `wr_en`=1 and `wr_victim`=1, the slot written is the one given by `victim_idx` in that cycle. The reserved slots 0 to 7 stay unchanged.
- R9: If several valid slots match, the result is taken from the one with the lowest index.
- R10: A lookup made in the same cycle as a write sees the contents as they were before that write.
- R11: In a cycle after one with `lk_req`=0, `lk_done`, `lk_hit` and `lk_miss` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address space identifier |
| lk_done | output | 1 | A registered result is present |
| lk_hit | output | 1 | Result: a match was found |
| lk_miss | output | 1 | Result: no match, software must refill |
| lk_paddr | output | 32 | Translated physical address |
| lk_slot | output | 6 | Index of the matching slot |
| wr_en | input | 1 | Write a slot this cycle |
| wr_victim | input | 1 | 1: write at `victim_idx`; 0: write at `wr_slot` |
| wr_slot | input | 6 | Explicit slot index |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 6 | Identifier to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_global | input | 1 | Match in every address space |
| wr_valid | input | 1 | Valid bit to store |
| victim_idx | output | 6 | Current victim counter value |

## Verification
All lookup results (`lk_done`, `lk_hit`, `lk_miss`, `lk_paddr`, `lk_slot`) are due on the first rising edge after the request. The bench drives a request on a falling edge and samples the outputs on the next falling edge, which lies halfway past the edge that registers them. A write takes effect at the edge that samples `wr_en`. The victim counter changes at every edge, so the bench reads `victim_idx` on the falling edge just before a victim write and treats that value as the slot written. Checks of the counter sequence compare samples taken on consecutive falling edges.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  // next value of a down-counter that wraps from lo back to hi
  function automatic int victim_after(input int cur, input int lo, input int hi);
    return (cur <= lo) ? hi : cur - 1;
  endfunction

  // physical address from a frame number and the page offset
  function automatic logic [63:0] join_addr(input logic [63:0] frame,
                                            input logic [63:0] offs,
                                            input int off_bits);
    return (frame << off_bits) | offs;
  endfunction
endpackage

// File: rtl/pxb_victim_ctr.sv
module pxb_victim_ctr #(
  parameter int SLOTS = 64,
  parameter int RESERVED = 8,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] victim
);
  import pxb_pkg::*;
  localparam logic [IW-1:0] LO = IW'(RESERVED);
  localparam logic [IW-1:0] HI = IW'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) victim <= HI;
    else        victim <= IW'(victim_after(int'(victim), RESERVED, SLOTS - 1));
  end

  p_victim_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victim >= LO);
  p_victim_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (victim != LO) |=> (victim == $past(victim) - 1'b1));
  p_victim_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (victim == LO) |=> (victim == HI));
endmodule

// File: rtl/pxb_slot_array.sv
module pxb_slot_array #(
  parameter int SLOTS = 64,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASID_W = 6,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic [SLOTS-1:0]  q_match,
  input  logic [IW-1:0]     rd_slot,
  output logic [PFN_W-1:0]  rd_pfn,
  input  logic              w_en,
  input  logic [IW-1:0]     w_slot,
  input  logic [VPN_W-1:0]  w_vpn,
  input  logic [ASID_W-1:0] w_asid,
  input  logic [PFN_W-1:0]  w_pfn,
  input  logic              w_global,
  input  logic              w_valid
);
  logic [VPN_W-1:0]  s_vpn  [SLOTS];
  logic [ASID_W-1:0] s_asid [SLOTS];
  logic [PFN_W-1:0]  s_pfn  [SLOTS];
  logic [SLOTS-1:0]  s_glob;
  logic [SLOTS-1:0]  s_val;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_val[g]  <= 1'b0;
        s_glob[g] <= 1'b0;
        s_vpn[g]  <= '0;
        s_asid[g] <= '0;
        s_pfn[g]  <= '0;
      end else if (w_en && (w_slot == IW'(g))) begin
        s_val[g]  <= w_valid;
        s_glob[g] <= w_global;
        s_vpn[g]  <= w_vpn;
        s_asid[g] <= w_asid;
        s_pfn[g]  <= w_pfn;
      end
    end
    assign q_match[g] = s_val[g] && (s_vpn[g] == q_vpn) &&
                        (s_glob[g] || (s_asid[g] == q_asid));
  end

  assign rd_pfn = s_pfn[rd_slot];
endmodule

// File: rtl/pxb_first_hit.sv
module pxb_first_hit #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] grant;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
    grant = '0;
    if (req != '0) grant[idx] = 1'b1;
  end
  assign any = |req;

  p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  p_grant_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & (grant - 1'b1)) == '0));
endmodule

// File: rtl/page_xlat_buffer.sv
module page_xlat_buffer #(
  parameter int SLOTS = 64,
  parameter int RESERVED = 8,
  parameter int PAGE_BITS = 12,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASID_W = 6,
  localparam int IW = $clog2(SLOTS),
  localparam int VA_W = VPN_W + PAGE_BITS,
  localparam int PA_W = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [IW-1:0]     lk_slot,
  input  logic              wr_en,
  input  logic              wr_victim,
  input  logic [IW-1:0]     wr_slot,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_global,
  input  logic              wr_valid,
  output logic [IW-1:0]     victim_idx
);
  import pxb_pkg::*;

  logic [SLOTS-1:0] match_vec;
  logic             match_any;
  logic [IW-1:0]    match_idx;
  logic [PFN_W-1:0] match_pfn;
  logic [IW-1:0]    write_at;
  logic [PA_W-1:0]  xlat_addr;

  pxb_victim_ctr #(.SLOTS(SLOTS), .RESERVED(RESERVED)) i_victim (
    .clk(clk), .rst_n(rst_n), .victim(victim_idx));

  assign write_at = wr_victim ? victim_idx : wr_slot;

  pxb_slot_array #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) i_slots (
    .clk(clk), .rst_n(rst_n),
    .q_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .q_asid(lk_asid), .q_match(match_vec),
    .rd_slot(match_idx), .rd_pfn(match_pfn),
    .w_en(wr_en), .w_slot(write_at), .w_vpn(wr_vpn), .w_asid(wr_asid),
    .w_pfn(wr_pfn), .w_global(wr_global), .w_valid(wr_valid));

  pxb_first_hit #(.N(SLOTS)) i_pick (
    .clk(clk), .rst_n(rst_n), .req(match_vec), .any(match_any), .idx(match_idx));

  assign xlat_addr = PA_W'(join_addr(64'(match_pfn),
                                     64'(lk_vaddr[PAGE_BITS-1:0]), PAGE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_paddr <= '0;
      lk_slot  <= '0;
    end else begin
      lk_done  <= lk_req;
      lk_hit   <= lk_req && match_any;
      lk_miss  <= lk_req && !match_any;
      lk_paddr <= (lk_req && match_any) ? xlat_addr : '0;
      lk_slot  <= (lk_req && match_any) ? match_idx : '0;
    end
  end

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (lk_done && (lk_hit != lk_miss)));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_done && !lk_hit && !lk_miss));
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && match_any) |=> (lk_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));
  p_victim_unreserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_victim) |-> (write_at >= IW'(RESERVED)));
endmodule

// File: tb/test_page_xlat_buffer.sv
module test_page_xlat_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [5:0]  lk_asid = '0;
  logic        lk_done, lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic [5:0]  lk_slot;
  logic        wr_en = 1'b0, wr_victim = 1'b0, wr_global = 1'b0, wr_valid = 1'b0;
  logic [5:0]  wr_slot = '0, wr_asid = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic [5:0]  victim_idx;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;
  int cycles = 0;

  always #2 clk = ~clk;

  page_xlat_buffer i_page_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .lk_slot(lk_slot), .wr_en(wr_en), .wr_victim(wr_victim), .wr_slot(wr_slot),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_global(wr_global),
    .wr_valid(wr_valid), .victim_idx(victim_idx));

  typedef struct packed {
    logic [31:0] va;
    logic [5:0]  asid;
    logic        hit;
    logic [31:0] pa;
    logic [5:0]  slot;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0001_0123, 6'd5,  1'b1, 32'h0ABC_D123, 6'd3},   // R2 reserved slot
    '{32'h0001_0FFF, 6'd6,  1'b0, 32'h0,         6'd0},   // R4 wrong id
    '{32'h0002_0000, 6'd5,  1'b1, 32'h1234_5000, 6'd20},  // R4
    '{32'h0002_0ABC, 6'd9,  1'b1, 32'h5432_1ABC, 6'd21},  // R4 same page, other id
    '{32'hFFFF_F001, 6'd33, 1'b1, 32'h0077_7001, 6'd63},  // R5 global
    '{32'h0000_1800, 6'd2,  1'b1, 32'h0004_2800, 6'd0},   // R6 slot 0
    '{32'h0000_2000, 6'd2,  1'b0, 32'h0,         6'd0},   // R3 unmapped
    '{32'hFFFF_FFFF, 6'd0,  1'b1, 32'h0077_7FFF, 6'd63}   // R5
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] slot, input logic [19:0] vpn, input logic [5:0] asid,
                     input logic [19:0] pfn, input logic g, input logic v);
    wr_en = 1'b1; wr_victim = 1'b0; wr_slot = slot; wr_vpn = vpn; wr_asid = asid;
    wr_pfn = pfn; wr_global = g; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic exp_hit,
                      input logic [31:0] exp_pa, input logic [5:0] exp_slot, input string tag);
    lk_req = 1'b1; lk_vaddr = va; lk_asid = asid;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_done && (lk_hit == exp_hit) && (lk_miss == !exp_hit), {tag, " hit/miss"},
        {lk_done, lk_hit, lk_miss}, {1'b1, exp_hit, !exp_hit});
    chk(lk_paddr == exp_pa, {tag, " paddr"}, lk_paddr, exp_pa);
    chk(lk_slot == exp_slot, {tag, " slot"}, lk_slot, exp_slot);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [5:0] vic_seen [56];

  initial begin
    repeat (3) @(negedge clk);
    chk(!lk_done && !lk_hit && !lk_miss, "R1 outputs in reset", {lk_done, lk_hit, lk_miss}, 0);
    chk(victim_idx == 6'd63, "R1 victim in reset", victim_idx, 63);
    rst_n = 1'b1;
    chk(victim_idx == 6'd63, "R1 victim after release", victim_idx, 63);
    look(32'h0001_0123, 6'd5, 1'b0, 32'h0, 6'd0, "R1 empty lookup");

    // R7 counter sequence observed at the port
    for (int i = 0; i < 70; i++) begin
      logic [5:0] prev;
      logic [5:0] want;
      prev = victim_idx;
      @(negedge clk);
      want = (prev == 6'd8) ? 6'd63 : prev - 6'd1;
      chk(victim_idx == want && victim_idx >= 6'd8, "R7 victim step", victim_idx, want);
    end

    put(6'd3,  20'h00010, 6'd5, 20'h0ABCD, 1'b0, 1'b1);
    put(6'd20, 20'h00020, 6'd5, 20'h12345, 1'b0, 1'b1);
    put(6'd21, 20'h00020, 6'd9, 20'h54321, 1'b0, 1'b1);
    put(6'd63, 20'hFFFFF, 6'd0, 20'h00777, 1'b1, 1'b1);
    put(6'd0,  20'h00001, 6'd2, 20'h00042, 1'b0, 1'b1);

    for (int k = 0; k < 8; k++)
      look(VECS[k].va, VECS[k].asid, VECS[k].hit, VECS[k].pa, VECS[k].slot,
           $sformatf("R2/R3/R4/R5/R6 vec%0d", k));

    // R11 idle cycle
    @(negedge clk);
    chk(!lk_done && !lk_hit && !lk_miss, "R11 idle", {lk_done, lk_hit, lk_miss}, 0);

    // R9 two slots with the same mapping, lowest index wins
    put(6'd40, 20'h00300, 6'd1, 20'h00040, 1'b0, 1'b1);
    put(6'd12, 20'h00300, 6'd1, 20'h00012, 1'b0, 1'b1);
    look(32'h0030_0456, 6'd1, 1'b1, 32'h0001_2456, 6'd12, "R9 lowest wins");
    put(6'd12, 20'h00300, 6'd1, 20'h00012, 1'b0, 1'b0);
    look(32'h0030_0456, 6'd1, 1'b1, 32'h0004_0456, 6'd40, "R6 invalidate");

    // R10 lookup and write in the same cycle
    wr_en = 1'b1; wr_victim = 1'b0; wr_slot = 6'd30; wr_vpn = 20'h00400; wr_asid = 6'd1;
    wr_pfn = 20'h0BEEF; wr_global = 1'b0; wr_valid = 1'b1;
    lk_req = 1'b1; lk_vaddr = 32'h0040_0010; lk_asid = 6'd1;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    chk(lk_miss && !lk_hit, "R10 old contents seen", {lk_hit, lk_miss}, 2'b01);
    look(32'h0040_0010, 6'd1, 1'b1, 32'h0BEE_F010, 6'd30, "R10 new contents");

    // R8 victim writes over 56 consecutive cycles
    for (int k = 0; k < 56; k++) begin
      vic_seen[k] = victim_idx;
      wr_en = 1'b1; wr_victim = 1'b1; wr_slot = 6'd0;
      wr_vpn = 20'h10000 + 20'(k); wr_asid = 6'd7; wr_pfn = 20'h20000 + 20'(k);
      wr_global = 1'b0; wr_valid = 1'b1;
      @(negedge clk);
    end
    wr_en = 1'b0; wr_victim = 1'b0;
    look(32'h1000_0000, 6'd7, 1'b1, 32'h2000_0000, vic_seen[0], "R8 victim first");
    look(32'h1001_B00C, 6'd7, 1'b1, 32'h2001_B00C, vic_seen[27], "R8 victim mid");
    look(32'h1003_7FFF, 6'd7, 1'b1, 32'h2003_7FFF, vic_seen[55], "R8 victim last");
    chk(vic_seen[0] >= 6'd8 && vic_seen[55] >= 6'd8, "R8 victim unreserved",
        {vic_seen[0], vic_seen[55]}, 0);
    look(32'h0001_0123, 6'd5, 1'b1, 32'h0ABC_D123, 6'd3, "R8 reserved kept");
    look(32'h0000_1800, 6'd2, 1'b1, 32'h0004_2800, 6'd0, "R8 reserved slot 0 kept");

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule